// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This engine feeds a byte-wide serial transmitter from a circular ring of buffer descriptors held in memory. Software fills descriptors and hands each one over by setting its ownership bit. The engine then walks the ring in order. For each descriptor it reads the ownership word first, then the buffer address and the byte count. It streams the buffer's bytes out on a valid/ready port and returns the descriptor to software by writing its ownership bit back to zero. Packets may span several consecutive descriptors. Start and end flags mark the first and last buffer of a packet.

Each descriptor is three 16-bit words, with a stride of 8 bytes, starting at byte address `RING_BASE + 8*index`. The words are laid out as follows:
- Word 0, at +0, holds buffer address bits 15:0.
- Word 1, at +2, holds buffer address bits 19:16 in bits 3:0. Bits 7:4 are reserved and ignored. Bit 8 is the end-of-packet flag, bit 9 is the start-of-packet flag and bit 15 is ownership.
- Word 2, at +4, holds the byte count in bits 11:0 and the per-buffer completion interrupt enable in bit 15.

The memory is addressed in bytes and read in 16-bit words. The low byte of a word sits at the even address.

Three events are recorded in a status register, and each has its own interrupt enable: end of packet, buffer unavailable, and buffer completion. Software reads the current descriptor index and the current transfer address through the same small register port.

Top module: `txring_dma`

## Requirements
- R1: After reset the control, status, index and transfer-address registers read zero, and `irq`, `tx_valid` and `mem_req` are low.
- R2: Register 0 is control; ctrl bit 0 is run. While run is set and the engine is idle, it reads word 1 of the current descriptor. A memory request holds its address and direction until `mem_ack`. If ownership (bit 15) is clear, status bit 1 is set, run is cleared by the engine, and no byte is sent.
- R3: The buffer address is word 0 joined with word 1 bits 3:0, and word 1 bits 7:4 are ignored. Bytes go out at increasing addresses, taken from the low half of a word at even addresses and the high half at odd ones.
- R4: Exactly word 2 bits 11:0 bytes are sent per buffer. A zero count sends nothing and sets no status bit.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R6: `tx_first` marks the first byte of a buffer whose word 1 bit 9 is set. `tx_last` marks the last byte of a buffer whose word 1 bit 8 is set. Buffers with neither flag carry the middle of a multi-buffer packet.
- R7: The cycle after the last byte of a buffer with word 1 bit 8 set is accepted, status bit 0 is set.
- R8: The cycle after the last byte of a buffer with word 2 bit 15 set is accepted, status bit 2 is set.
- R9: `irq` is high exactly when a status bit is set whose enable is set: status 0 uses ctrl bit 1, status 1 uses ctrl bit 2, and status 2 uses ctrl bit 3.
- R10: Register 1 is status, and writing ones clears the matching bits. When a clear and a hardware set hit the same bit in the same cycle, the set wins.
- R11: On finishing a buffer, the engine writes word 1 back with bit 15 cleared and every other bit unchanged, then advances the index. When ctrl bit 4 is set, the write-back is skipped and ownership stays set.
- R12: Register 2 is the index. The ring holds 2^ctrl[7:5] entries, limited to 2^IW, and the index wraps from the last entry to 0. A write to the index is masked to the ring size. A ring of one entry keeps reusing entry 0.
- R13: Register 3 is the transfer address of the next byte. After a buffer completes, it holds that buffer's start address plus its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 index, 3 transfer address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | AW | Register read data, combinational on reg_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a packet |
| tx_last | output | 1 | Last byte of a packet |

## Verification
The bench sets up one same-cycle collision on purpose. When it predicts that the last byte of an end-of-packet buffer will be accepted at the next edge, it drives a write-one-to-clear of that status bit in the same cycle. It then expects the bit to read back as set afterwards. A second overlap occurs at every descriptor boundary. A status set from the data path and a clear from the register port both enter the same per-clock reference prediction, which is compared against the status register and `irq` on every cycle.

// File: rtl/txring_dma.sv
`timescale 1ns/1ps
module txring_dma #(
  parameter int AW = 20,
  parameter int CW = 12,
  parameter int IW = 3,
  parameter int RING_BASE = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last
);
  typedef enum logic [2:0] {S_IDLE, S_W1, S_W0, S_W2, S_RD, S_TX, S_WB, S_ADV} st_t;

  st_t           st;
  logic [7:0]    ctrl;
  logic [2:0]    stat;
  logic [IW-1:0] idx;
  logic [AW-1:0] xaddr;
  logic [14:0]   w1;
  logic [CW-1:0] cnt;
  logic          tce, first_pend;
  logic [7:0]    txb;

  logic [2:0]    lg;
  logic [IW-1:0] mask;
  logic [AW-1:0] dbase;
  st_t           fin_st;

  assign lg     = (int'(ctrl[7:5]) > IW) ? 3'(IW) : ctrl[7:5];
  assign mask   = IW'((32'd1 << lg) - 32'd1);
  assign dbase  = AW'(RING_BASE) + AW'({idx, 3'b000});
  assign fin_st = ctrl[4] ? S_ADV : S_WB;

  wire wr_ctrl  = reg_wr && reg_addr == 2'd0;
  wire wr_stat  = reg_wr && reg_addr == 2'd1;
  wire wr_idx   = reg_wr && reg_addr == 2'd2;
  wire last_one = cnt == CW'(1);
  wire done_hs  = tx_valid && tx_ready && last_one;
  wire unav_hit = st == S_W1 && mem_ack && !mem_rdata[15];

  assign tx_valid  = st == S_TX;
  assign tx_data   = txb;
  assign tx_first  = tx_valid && first_pend;
  assign tx_last   = tx_valid && last_one && w1[8];
  assign irq       = |(stat & ctrl[3:1]);
  assign mem_req   = st inside {S_W1, S_W0, S_W2, S_RD, S_WB};
  assign mem_we    = st == S_WB;
  assign mem_wdata = {1'b0, w1};

  always_comb begin
    case (st)
      S_W0:       mem_addr = dbase;
      S_W1, S_WB: mem_addr = dbase + AW'(2);
      S_W2:       mem_addr = dbase + AW'(4);
      S_RD:       mem_addr = {xaddr[AW-1:1], 1'b0};
      default:    mem_addr = '0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = AW'(ctrl);
      2'd1:    reg_rdata = AW'(stat);
      2'd2:    reg_rdata = AW'(idx);
      default: reg_rdata = xaddr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ctrl <= '0;
      stat <= '0;
      idx <= '0;
      xaddr <= '0;
      w1 <= '0;
      cnt <= '0;
      tce <= 1'b0;
      first_pend <= 1'b0;
      txb <= '0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata;
      if (unav_hit) ctrl[0] <= 1'b0;
      stat <= (stat & ~(wr_stat ? reg_wdata[2:0] : 3'b000))
            | {done_hs && tce, unav_hit, done_hs && w1[8]};
      if (st == S_ADV) idx <= (idx + IW'(1)) & mask;
      if (wr_idx) idx <= reg_wdata[IW-1:0] & mask;
      case (st)
        S_IDLE: if (ctrl[0]) st <= S_W1;
        S_W1: if (mem_ack) begin
          w1 <= mem_rdata[14:0];
          st <= mem_rdata[15] ? S_W0 : S_IDLE;
        end
        S_W0: if (mem_ack) begin
          xaddr <= AW'({w1[3:0], mem_rdata});
          st <= S_W2;
        end
        S_W2: if (mem_ack) begin
          cnt <= mem_rdata[CW-1:0];
          tce <= mem_rdata[15];
          first_pend <= w1[9];
          st <= (mem_rdata[CW-1:0] == '0) ? fin_st : S_RD;
        end
        S_RD: if (mem_ack) begin
          txb <= xaddr[0] ? mem_rdata[15:8] : mem_rdata[7:0];
          st <= S_TX;
        end
        S_TX: if (tx_ready) begin
          xaddr <= xaddr + AW'(1);
          cnt <= cnt - CW'(1);
          first_pend <= 1'b0;
          st <= last_one ? fin_st : S_RD;
        end
        S_WB: if (mem_ack) st <= S_ADV;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r2_unav_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> !ctrl[0]);

  a_r7_eop_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> stat[0]);

  a_r4_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_W2 && mem_ack && mem_rdata[CW-1:0] == '0 |=> !tx_valid);
endmodule

// File: tb/txring_dma_test.sv
`timescale 1ns/1ps
module txring_dma_test;
  localparam int RB = 'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd1;
  logic [7:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b0, tx_first, tx_last;
  logic [7:0] tx_data;

  txring_dma #(.AW(20), .CW(12), .IW(3), .RING_BASE(RB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last));

  initial forever #2 clk = ~clk;

  logic [15:0] mem [0:8191];
  logic [12:0] q [$];
  logic [2:0] ms = '0, en = '0;
  int checks = 0, fails = 0, wcnt = 0, lcnt = 0, txmode = 0;
  logic arm = 1'b0, coll = 1'b0, done = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [19:0] rd;

  function automatic int mi(logic [19:0] a);
    return int'({a[17:16], a[11:1]});
  endfunction

  function automatic logic [7:0] bget(logic [19:0] a);
    logic [15:0] w = mem[mi(a)];
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic put_desc(int i, logic [19:0] a, int n, logic s, logic e, logic t, logic own, logic [3:0] g);
    logic [19:0] b = 20'(RB + 8 * i);
    mem[mi(b)] = a[15:0];
    mem[mi(b + 2)] = {own, 5'b0, s, e, g, a[19:16]};
    mem[mi(b + 4)] = {t, 3'b0, 12'(n)};
  endtask

  task automatic exp_buf(logic [19:0] a, int n, logic s, logic e, logic t);
    for (int j = 0; j < n; j++) begin
      logic be = (j == n - 1);
      q.push_back({t, e, be, be && e, s && j == 0, bget(a + 20'(j))});
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [19:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1;
    reg_addr = 2'd1;
  endtask

  task automatic wait_quiet();
    int n = 0;
    while (n < 20) begin
      @(negedge clk);
      n = (!mem_req && !tx_valid) ? n + 1 : 0;
    end
  endtask

  initial begin
    forever begin
      logic [12:0] e;
      logic hs, unav_now;
      logic [2:0] clr;
      @(negedge clk);
      if (rst_n) begin
        chk("R9 irq", 32'(irq), 32'(|(ms & en)));
        if (reg_addr == 2'd1 && !reg_wr) chk("R7 R8 R10 status", 32'(reg_rdata[2:0]), 32'(ms));
        if (tx_valid) begin
          if (q.size() == 0) chk("R4 unexpected byte", 32'(tx_data), 32'hFFFF_FFFF);
          else chk("R3 R5 R6 byte/first/last", {22'b0, tx_first, tx_last, tx_data},
                   {22'b0, q[0][8], q[0][9], q[0][7:0]});
        end
        if (coll) begin reg_wr = 1'b0; reg_addr = 2'd1; coll = 1'b0; end
        unav_now = 1'b0;
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
          if (wcnt == 0) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mi(mem_addr)] = mem_wdata;
            else begin
              mem_rdata = mem[mi(mem_addr)];
              if (mem_addr >= 20'(RB) && mem_addr < 20'(RB + 64) &&
                  mem_addr[2:0] == 3'd2 && !mem_rdata[15]) unav_now = 1'b1;
            end
            lcnt++;
            wcnt = lcnt % 3;
          end else wcnt--;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (txmode)
          0: tx_ready = 1'b1;
          1: tx_ready = ~tx_ready;
          default: tx_ready = lfsr[0];
        endcase
        hs = tx_valid && tx_ready && q.size() > 0;
        e = hs ? q[0] : '0;
        if (hs && arm && e[10] && e[11]) begin
          reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
          arm = 1'b0; coll = 1'b1;
        end
        clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[2:0] : 3'b000;
        if (reg_wr && reg_addr == 2'd0) en = reg_wdata[3:1];
        ms = (ms & ~clr) | {e[10] && e[12], unav_now, e[10] && e[11]};
        if (hs) void'(q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int k = 0; k < 8192; k++) mem[k] = 16'(k * 40503) ^ 16'h5A5A;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);
    reg_read(2'd0, rd); chk("R1 ctrl", 32'(rd), 0);
    reg_read(2'd1, rd); chk("R1 status", 32'(rd), 0);
    reg_read(2'd2, rd); chk("R1 index", 32'(rd), 0);
    reg_read(2'd3, rd); chk("R1 xaddr", 32'(rd), 0);

    // four-entry ring, multi-buffer packet, zero count, wrap into an unowned entry
    put_desc(0, 20'h00401, 5, 1, 1, 1, 1, 4'h0);
    put_desc(1, 20'h10600, 3, 1, 0, 0, 1, 4'hA);
    put_desc(2, 20'h00500, 4, 0, 1, 1, 1, 4'h0);
    put_desc(3, 20'h00700, 0, 1, 1, 1, 1, 4'h0);
    exp_buf(20'h00401, 5, 1, 1, 1);
    exp_buf(20'h10600, 3, 1, 0, 0);
    exp_buf(20'h00500, 4, 0, 1, 1);
    txmode = 1; arm = 1'b1;
    reg_write(2'd0, 8'h4F);
    wait_quiet();
    chk("R4 all bytes sent", 32'(q.size()), 0);
    chk("R10 set wins over clear", 32'(arm), 0);
    reg_read(2'd1, rd); chk("R2 R7 R8 status", 32'(rd), 32'h7);
    reg_read(2'd0, rd); chk("R2 run cleared", 32'(rd), 32'h4E);
    reg_read(2'd2, rd); chk("R12 wrapped index", 32'(rd), 0);
    reg_read(2'd3, rd); chk("R13 xaddr", 32'(rd), 32'h00700);
    chk("R11 desc0 word1", 32'(mem[mi(20'(RB + 2))]), 32'h0300);
    chk("R11 desc1 word1", 32'(mem[mi(20'(RB + 10))]), 32'h02A1);
    chk("R11 desc2 word1", 32'(mem[mi(20'(RB + 18))]), 32'h0100);
    chk("R11 desc3 word1", 32'(mem[mi(20'(RB + 26))]), 32'h0300);
    reg_write(2'd1, 8'h05);
    reg_read(2'd1, rd); chk("R10 partial clear", 32'(rd), 32'h2);
    reg_write(2'd1, 8'h07);
    @(negedge clk); chk("R9 irq after clear", 32'(irq), 0);

    // single-entry ring with ownership kept
    put_desc(0, 20'h00801, 2, 1, 1, 0, 1, 4'h0);
    exp_buf(20'h00801, 2, 1, 1, 0);
    txmode = 0;
    reg_write(2'd0, 8'h13);
    while (!tx_valid) @(negedge clk);
    reg_write(2'd0, 8'h12);
    wait_quiet();
    chk("R4 single entry bytes", 32'(q.size()), 0);
    chk("R11 own kept", 32'(mem[mi(20'(RB + 2))]), 32'h8300);
    reg_read(2'd2, rd); chk("R12 ring of one", 32'(rd), 0);
    reg_read(2'd3, rd); chk("R13 xaddr", 32'(rd), 32'h00803);
    reg_read(2'd1, rd); chk("R7 status", 32'(rd), 32'h1);
    reg_write(2'd1, 8'h07);

    // eight-entry ring, start mid ring, packet across the wrap
    reg_write(2'd0, 8'h68);
    reg_write(2'd2, 8'h0D);
    reg_read(2'd2, rd); chk("R12 index masked", 32'(rd), 5);
    reg_write(2'd2, 8'h06);
    reg_read(2'd2, rd); chk("R12 index write", 32'(rd), 6);
    put_desc(6, 20'h00900, 3, 1, 0, 0, 1, 4'h0);
    put_desc(7, 20'h00A03, 2, 0, 0, 1, 1, 4'h0);
    put_desc(0, 20'h00B00, 4, 0, 1, 0, 1, 4'h0);
    put_desc(1, 20'h00C00, 4, 1, 1, 0, 0, 4'h0);
    exp_buf(20'h00900, 3, 1, 0, 0);
    exp_buf(20'h00A03, 2, 0, 0, 1);
    exp_buf(20'h00B00, 4, 0, 1, 0);
    txmode = 2;
    reg_write(2'd0, 8'h69);
    wait_quiet();
    chk("R4 wrap bytes", 32'(q.size()), 0);
    reg_read(2'd2, rd); chk("R12 wrap index", 32'(rd), 1);
    reg_read(2'd3, rd); chk("R13 xaddr", 32'(rd), 32'h00B04);
    reg_read(2'd1, rd); chk("R2 R7 R8 status", 32'(rd), 32'h7);
    chk("R11 desc6 word1", 32'(mem[mi(20'(RB + 50))]), 32'h0200);
    chk("R11 desc7 word1", 32'(mem[mi(20'(RB + 58))]), 32'h0000);
    chk("R2 unowned untouched", 32'(mem[mi(20'(RB + 10))]), 32'h0300);
    @(negedge clk); chk("R9 irq tc only", 32'(irq), 1);
    summary();
  end
endmodule